// File: doc/BRIEF.md
# Windowed Register File

This block is the register file for a three-operand datapath. Each instruction sees 32 logical registers. Behind them sits a larger physical array that is cut into a ring of overlapping windows. A current window pointer picks the active window. Each cycle there are two combinational reads and one write, and the write is stored at the clock edge.

Two strobes move the pointer. A call strobe steps it forward one window and a return strobe steps it back one. Neighbouring windows share eight physical registers. As a result, whatever a caller leaves in its outgoing-parameter group is already present in the callee's incoming-parameter group, and no data is copied. The block keeps a count of live windows. When a call would run into storage that is still in use, or a return would pass the oldest live window, it raises a one-cycle flag. The pointer moves in both cases, and spilling or refilling windows is left to logic outside the block.

The logical map is: 0–7 globals, 8–15 outgoing, 16–23 locals, 24–31 incoming. The physical array holds 8 globals plus 16 windows of 16 entries each, 264 entries in total.

Top module: `winreg_file`

## Requirements
- R1: A synchronous active-high reset sets the window pointer to 0, clears the live-window count and both flags, and makes every logical register read as zero.
- R2: Logical register 0 always reads as zero on both read ports, including when a write to it is presented in the same cycle. A write to register 0 is discarded.
- R3: A write with enable high is stored at the clock edge. From the next cycle, either read port returns the stored value for that register, and the two read ports are independent of each other.
- R4: When the write enable is high and the write register equals a read register (other than 0), that read port returns the incoming write data in the same cycle (write-first).
- R5: Logical registers 1–7 are globals. They name the same storage in every window.
- R6: After a call, logical register 24+k of the new window reads the value the caller held in logical register 8+k (k = 0..7). After a return, the caller's register 8+k reads what the callee held in 24+k.
- R7: Logical registers 16–23 are private to each window. Writes to them are invisible from the next window and are still present after returning.
- R8: A call alone adds 1 to the window pointer and a return subtracts 1, both modulo 16. The new pointer is visible from the cycle after the strobe edge.
- R9: When call and return are asserted in the same cycle, only the return is carried out.
- R10: The live-window count rises on a call and saturates at 15. A call made while the count is 15 raises the overflow flag for exactly the cycle after that edge, and the pointer still advances.
- R11: A return made while the live-window count is 0 raises the underflow flag for exactly the cycle after that edge, and the pointer still steps back (0 to 15). A return with a nonzero count lowers the count and raises no flag.
- R12: The overflow and underflow flags are never high together, and each is low in any cycle that does not directly follow a strobe edge of its kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Step the window pointer forward one window |
| ret_i | input | 1 | Step the window pointer back one window; wins over call_i |
| rs1_i | input | 5 | Logical register for read port 1 |
| rs2_i | input | 5 | Logical register for read port 2 |
| rd_i | input | 5 | Logical register to write |
| we_i | input | 1 | Write enable |
| wd_i | input | 32 | Write data |
| rd1_o | output | 32 | Read port 1 data (combinational) |
| rd2_o | output | 32 | Read port 2 data (combinational) |
| cwp_o | output | 4 | Current window pointer |
| ovf_o | output | 1 | Window overflow flag, one-cycle pulse |
| unf_o | output | 1 | Window underflow flag, one-cycle pulse |

## Verification
Read data depends combinationally on the current pointer and the read addresses. A read of a bypassed write is therefore sampled in the same cycle the write is presented, and a stored value is sampled the cycle after its write edge. The pointer and both flags come out of registers, so each strobe is checked just after the edge that takes it in. Each flag is checked again one cycle later to confirm the pulse has ended. Every bench task changes inputs a couple of nanoseconds after a rising edge and samples after a further short settle, so no sample ever falls on an edge.

// File: rtl/winreg_pkg.sv
`timescale 1ns/1ps
package winreg_pkg;

    localparam int NWIN    = 16;            // windows in the ring
    localparam int GSZ     = 8;             // registers per group
    localparam int XLEN    = 32;            // data width

    localparam int WSTRIDE = 2 * GSZ;       // new entries per window
    localparam int RING    = NWIN * WSTRIDE;
    localparam int PHYS    = GSZ + RING;
    localparam int CWP_W   = $clog2(NWIN);
    localparam int PIDX_W  = $clog2(PHYS);
    localparam int OFF_W   = $clog2(GSZ);
    localparam int LIDX_W  = $clog2(4 * GSZ);
    localparam int NRD     = 2;
    localparam int LIVE_MAX = NWIN - 1;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [LIDX_W-1:0] lreg_t;
    typedef logic [PIDX_W-1:0] pidx_t;
    typedef logic [CWP_W-1:0]  cwp_t;

    // group code = upper two bits of the logical number
    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } grp_e;

    typedef enum logic [1:0] {
        EVT_NONE,
        EVT_CALL,
        EVT_RET
    } win_evt_e;

    typedef struct packed {
        logic  en;
        pidx_t idx;
        word_t data;
    } store_wr_t;

    // Window w: ins at ring w*16+0..7, locals at w*16+8..15,
    // outs at (w+1)*16+0..7, i.e. the ins of window w+1.
    function automatic pidx_t phys_of(cwp_t cwp, lreg_t lreg);
        int off;
        int base;
        int ring_pos;
        off  = int'(lreg[OFF_W-1:0]);
        base = int'(cwp) * WSTRIDE;
        case (grp_e'(lreg[LIDX_W-1:OFF_W]))
            GRP_GLB: ring_pos = -1;
            GRP_IN:  ring_pos = base + off;
            GRP_LOC: ring_pos = base + GSZ + off;
            default: ring_pos = base + WSTRIDE + off;
        endcase
        if (ring_pos < 0)
            return PIDX_W'(off);
        return PIDX_W'(GSZ + (ring_pos % RING));
    endfunction

    function automatic win_evt_e evt_of(logic call, logic ret);
        if (ret)
            return EVT_RET;
        if (call)
            return EVT_CALL;
        return EVT_NONE;
    endfunction

endpackage

// File: rtl/winreg_cwp_ctrl.sv
`timescale 1ns/1ps
module winreg_cwp_ctrl
    import winreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic call_i,
    input  logic ret_i,
    output cwp_t cwp_o,
    output logic ovf_o,
    output logic unf_o
);

    cwp_t     cwp_q;
    cwp_t     live_q;
    logic     ovf_q;
    logic     unf_q;
    win_evt_e evt;

    assign evt = evt_of(call_i, ret_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q  <= '0;
            live_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            case (evt)
                EVT_RET: begin
                    cwp_q <= cwp_q - cwp_t'(1);
                    if (live_q == '0)
                        unf_q <= 1'b1;
                    else
                        live_q <= live_q - cwp_t'(1);
                end
                EVT_CALL: begin
                    cwp_q <= cwp_q + cwp_t'(1);
                    if (live_q == cwp_t'(LIVE_MAX))
                        ovf_q <= 1'b1;
                    else
                        live_q <= live_q + cwp_t'(1);
                end
                default: ;
            endcase
        end
    end

    assign cwp_o = cwp_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

endmodule

// File: rtl/winreg_map.sv
`timescale 1ns/1ps
module winreg_map
    import winreg_pkg::*;
(
    input  cwp_t  cwp_i,
    input  lreg_t lreg_i,
    output pidx_t pidx_o,
    output logic  zero_o
);

    assign pidx_o = phys_of(cwp_i, lreg_i);
    assign zero_o = (lreg_i == '0);

endmodule

// File: rtl/winreg_store.sv
`timescale 1ns/1ps
module winreg_store
    import winreg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  store_wr_t wr_i,
    input  pidx_t     ridx_i [NRD],
    output word_t     rdat_o [NRD]
);

    word_t mem [PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS; i++)
                mem[i] <= '0;
        end else if (wr_i.en) begin
            mem[wr_i.idx] <= wr_i.data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdat_o[p] = mem[ridx_i[p]];
    end

endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file
    import winreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic [4:0]       rs1_i,
    input  logic [4:0]       rs2_i,
    input  logic [4:0]       rd_i,
    input  logic             we_i,
    input  logic [31:0]      wd_i,
    output logic [31:0]      rd1_o,
    output logic [31:0]      rd2_o,
    output logic [3:0]       cwp_o,
    output logic             ovf_o,
    output logic             unf_o
);

    cwp_t      cwp;
    lreg_t     rsel   [NRD];
    pidx_t     ridx   [NRD];
    logic      rzero  [NRD];
    word_t     rraw   [NRD];
    word_t     rout   [NRD];
    pidx_t     widx;
    logic      wzero;
    store_wr_t wreq;

    winreg_cwp_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp_o  (cwp),
        .ovf_o  (ovf_o),
        .unf_o  (unf_o)
    );

    assign rsel[0] = rs1_i;
    assign rsel[1] = rs2_i;

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        winreg_map u_rmap (
            .cwp_i  (cwp),
            .lreg_i (rsel[p]),
            .pidx_o (ridx[p]),
            .zero_o (rzero[p])
        );

        always_comb begin
            if (rzero[p])
                rout[p] = '0;
            else if (we_i && (rd_i == rsel[p]))
                rout[p] = wd_i;
            else
                rout[p] = rraw[p];
        end
    end

    winreg_map u_wmap (
        .cwp_i  (cwp),
        .lreg_i (rd_i),
        .pidx_o (widx),
        .zero_o (wzero)
    );

    assign wreq = '{en: we_i && !wzero, idx: widx, data: wd_i};

    winreg_store u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wreq),
        .ridx_i (ridx),
        .rdat_o (rraw)
    );

    assign rd1_o = rout[0];
    assign rd2_o = rout[1];
    assign cwp_o = cwp;

endmodule

// File: rtl/winreg_file_chk.sv
`timescale 1ns/1ps
module winreg_file_chk (
    input logic        clk,
    input logic        rst,
    input logic        call_i,
    input logic        ret_i,
    input logic [4:0]  rs1_i,
    input logic [4:0]  rs2_i,
    input logic [4:0]  rd_i,
    input logic        we_i,
    input logic [31:0] wd_i,
    input logic [31:0] rd1_o,
    input logic [31:0] rd2_o,
    input logic [3:0]  cwp_o,
    input logic        ovf_o,
    input logic        unf_o
);

    assert_zero_rd1_R2: assert property (@(posedge clk) disable iff (rst)
        (rs1_i == 5'd0) |-> (rd1_o == 32'd0));

    assert_zero_rd2_R2: assert property (@(posedge clk) disable iff (rst)
        (rs2_i == 5'd0) |-> (rd2_o == 32'd0));

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (we_i && rd_i != 5'd0 && !call_i && !ret_i) |=>
        ((rs1_i != $past(rd_i)) || (we_i && rd_i == rs1_i) || (rd1_o == $past(wd_i))));

    assert_call_step_R8: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i) |=> (cwp_o == 4'($past(cwp_o) + 4'd1)));

    assert_ret_wins_R9: assert property (@(posedge clk) disable iff (rst)
        ret_i |=> (cwp_o == 4'($past(cwp_o) - 4'd1)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!call_i && !ret_i) |=> $stable(cwp_o));

    assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $past(call_i && !ret_i));

    assert_unf_cause_R11: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> $past(ret_i));

    assert_flags_excl_R12: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));

endmodule

bind winreg_file winreg_file_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .call_i (call_i),
    .ret_i  (ret_i),
    .rs1_i  (rs1_i),
    .rs2_i  (rs2_i),
    .rd_i   (rd_i),
    .we_i   (we_i),
    .wd_i   (wd_i),
    .rd1_o  (rd1_o),
    .rd2_o  (rd2_o),
    .cwp_o  (cwp_o),
    .ovf_o  (ovf_o),
    .unf_o  (unf_o)
);

// File: tb/test_winreg_file.sv
`timescale 1ns/1ps
module test_winreg_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic [4:0]  rs1_i = '0;
    logic [4:0]  rs2_i = '0;
    logic [4:0]  rd_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] wd_i = '0;
    logic [31:0] rd1_o;
    logic [31:0] rd2_o;
    logic [3:0]  cwp_o;
    logic        ovf_o;
    logic        unf_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    winreg_file i_winreg_file (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .rs1_i(rs1_i), .rs2_i(rs2_i), .rd_i(rd_i), .we_i(we_i), .wd_i(wd_i),
        .rd1_o(rd1_o), .rd2_o(rd2_o), .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst = 1'b1; call_i = 0; ret_i = 0; we_i = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] r, input logic [31:0] d);
        rd_i = r; wd_i = d; we_i = 1'b1;
        tick();
        we_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        rs1_i = a; rs2_i = a;
        #1;
        chk(req, rd1_o, exp);
        chk(req, rd2_o, exp);
    endtask

    task automatic strobe(input logic c, input logic r);
        call_i = c; ret_i = r;
        tick();
        call_i = 0; ret_i = 0;
    endtask

    task automatic t_reset_state();   // R1
        do_reset();
        #1;
        chk("R1 cwp", 32'(cwp_o), 32'd0);
        chk("R1 ovf", 32'(ovf_o), 32'd0);
        chk("R1 unf", 32'(unf_o), 32'd0);
        rd_chk("R1 r5", 5'd5, 32'd0);
        rd_chk("R1 r12", 5'd12, 32'd0);
        rd_chk("R1 r20", 5'd20, 32'd0);
        rd_chk("R1 r31", 5'd31, 32'd0);
    endtask

    task automatic t_reg_zero();      // R2
        wr(5'd0, 32'hDEAD_BEEF);
        rd_chk("R2 r0 after write", 5'd0, 32'd0);
        rd_i = 5'd0; wd_i = 32'h1234_5678; we_i = 1'b1;
        rs1_i = 5'd0; rs2_i = 5'd0;
        #1;
        chk("R2 r0 bypass p1", rd1_o, 32'd0);
        chk("R2 r0 bypass p2", rd2_o, 32'd0);
        tick();
        we_i = 1'b0;
        rd_chk("R2 r0 later", 5'd0, 32'd0);
    endtask

    task automatic t_write_read();    // R3
        wr(5'd3, 32'hA5A5_0003);
        wr(5'd12, 32'h0000_C00C);
        wr(5'd30, 32'h3030_3030);
        rs1_i = 5'd3; rs2_i = 5'd12;
        #1;
        chk("R3 port1 r3", rd1_o, 32'hA5A5_0003);
        chk("R3 port2 r12", rd2_o, 32'h0000_C00C);
        rs1_i = 5'd30; rs2_i = 5'd3;
        #1;
        chk("R3 port1 r30", rd1_o, 32'h3030_3030);
        chk("R3 port2 r3", rd2_o, 32'hA5A5_0003);
    endtask

    task automatic t_bypass();        // R4
        wr(5'd7, 32'h0000_0001);
        rd_i = 5'd7; wd_i = 32'h0000_0002; we_i = 1'b1;
        rs1_i = 5'd7; rs2_i = 5'd3;
        #1;
        chk("R4 bypass port1", rd1_o, 32'h0000_0002);
        chk("R4 other port", rd2_o, 32'hA5A5_0003);
        rs1_i = 5'd3; rs2_i = 5'd7;
        #1;
        chk("R4 bypass port2", rd2_o, 32'h0000_0002);
        tick();
        we_i = 1'b0;
        rd_chk("R4 stored", 5'd7, 32'h0000_0002);
    endtask

    task automatic t_windows();       // R5 R6 R7 R8
        do_reset();
        wr(5'd5, 32'h6100_0005);
        wr(5'd8, 32'h0800_0000);
        wr(5'd15, 32'h0F00_0000);
        wr(5'd16, 32'h1600_00AA);
        strobe(1'b1, 1'b0);
        chk("R8 call step", 32'(cwp_o), 32'd1);
        rd_chk("R5 global after call", 5'd5, 32'h6100_0005);
        rd_chk("R6 in24 = out8", 5'd24, 32'h0800_0000);
        rd_chk("R6 in31 = out15", 5'd31, 32'h0F00_0000);
        rd_chk("R7 callee local clean", 5'd16, 32'd0);
        rd_chk("R6 callee out clean", 5'd8, 32'd0);
        wr(5'd16, 32'h1600_00BB);
        wr(5'd25, 32'h2500_0001);
        wr(5'd6, 32'h6600_0006);
        strobe(1'b0, 1'b1);
        chk("R8 return step", 32'(cwp_o), 32'd0);
        rd_chk("R7 caller local kept", 5'd16, 32'h1600_00AA);
        rd_chk("R6 out9 = callee in25", 5'd9, 32'h2500_0001);
        rd_chk("R5 global after return", 5'd6, 32'h6600_0006);
    endtask

    task automatic t_priority();      // R9
        do_reset();
        strobe(1'b1, 1'b0);
        chk("R9 setup", 32'(cwp_o), 32'd1);
        strobe(1'b1, 1'b1);
        chk("R9 return wins", 32'(cwp_o), 32'd0);
        chk("R9 no ovf", 32'(ovf_o), 32'd0);
        chk("R9 no unf", 32'(unf_o), 32'd0);
    endtask

    task automatic t_overflow();      // R10 R12
        do_reset();
        for (int i = 0; i < 15; i++) begin
            strobe(1'b1, 1'b0);
            chk("R10 no ovf below limit", 32'(ovf_o), 32'd0);
        end
        chk("R8 cwp after 15 calls", 32'(cwp_o), 32'd15);
        strobe(1'b1, 1'b0);
        chk("R10 ovf pulse", 32'(ovf_o), 32'd1);
        chk("R10 cwp wraps", 32'(cwp_o), 32'd0);
        tick();
        chk("R12 ovf drops", 32'(ovf_o), 32'd0);
        strobe(1'b0, 1'b1);
        chk("R11 return with live count", 32'(unf_o), 32'd0);
        chk("R8 cwp after return", 32'(cwp_o), 32'd15);
    endtask

    task automatic t_underflow();     // R11 R12
        do_reset();
        strobe(1'b0, 1'b1);
        chk("R11 unf pulse", 32'(unf_o), 32'd1);
        chk("R11 cwp wraps back", 32'(cwp_o), 32'd15);
        chk("R12 ovf low", 32'(ovf_o), 32'd0);
        tick();
        chk("R12 unf drops", 32'(unf_o), 32'd0);
        strobe(1'b1, 1'b0);
        chk("R10 call after unf", 32'(ovf_o), 32'd0);
        chk("R8 cwp call", 32'(cwp_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_reg_zero();
        t_write_read();
        t_bypass();
        t_windows();
        t_priority();
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule